// File: doc/BRIEF.md
# Audio Codec Control Register Bank

This block is the write side of an audio codec's control port. A host shifts 16-bit command words in over a three-wire serial link made of a control clock, an active-low select and a data line. The upper seven bits of each word name a register and the lower nine bits carry the value. The block decodes each completed word and updates the addressed 9-bit register. It drives the whole register image out in parallel, so the converter datapath can read its settings directly.

Seven attenuation channels need special handling: three stereo DAC pairs and one master control. Each channel keeps the last written code as a pending value. The code the datapath actually uses changes only when a write carries the update flag. For a stereo pair, that one write moves the pending codes of both sides into use at the same time, so left and right never disagree for a cycle. Writing any value to the reset address, or raising the reset input, reloads every register with its power-on default. The serial port cannot be stalled: each completed word is taken in the cycle after it finishes, and there is no back-pressure.

Top module: `codec_ctl_regfile`

## Requirements
- R1: A word is framed by `ctl_cs_n` low and consists of 16 bits taken MSB first, one on each rising edge of `ctl_sck`. Word bits 15..9 form the register address and bits 8..0 form the data. The new value appears on `reg_flat[9*a +: 9]` no later than two `clk` edges after the edge that samples the 16th rise.
- R2: A write to any mapped address other than 0x35 stores the 9-bit data at that address and leaves every other register unchanged.
- R3: A write of any value to address 0x35 restores every register to its default. Examples of defaults: 0x121 at 0x00, 0x01C at 0x08, 0x1F0 at 0x1C, 0x05E at 0x32, 0x03E at 0x33. Active attenuation codes return to 0xFF for the six DAC channels and 0xF0 for the master.
- R4: A cycle with `rst` high has the same effect as R3, and it also clears any partly received word.
- R5: Addresses 0x14..0x19 are attenuation channels 0..5, ordered left then right for pairs 1, 2 and 3. Address 0x1C is channel 6, the master. Data bits 7..0 are the code and bit 8 is the update flag. A write with bit 8 clear changes only the stored register; `att_code` is unchanged.
- R6: A write with bit 8 set to a pair channel loads that channel's `att_code` with the written code. In the same cycle it loads the partner channel (index XOR 1) with the partner's stored code. Other channels are unchanged.
- R7: A write with bit 8 set to address 0x1C loads only channel 6.
- R8: A write to an unmapped address (0x1A, 0x1B, or above 0x35) changes no register and raises `cmd_err` for exactly one cycle. A mapped write never raises it.
- R9: Raising `ctl_cs_n` before the 16th bit discards the partial word. The next full word decodes normally.
- R10: `att_mute[c]` is high exactly when `att_code[8*c +: 8]` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the control clock is sampled in this domain |
| rst | input | 1 | Synchronous active-high reset to defaults |
| ctl_sck | input | 1 | Serial control clock, synchronous to `clk` |
| ctl_cs_n | input | 1 | Active-low word frame |
| ctl_sdi | input | 1 | Serial data, MSB first |
| reg_flat | output | 486 | Register image, address a at bits 9a+8..9a |
| att_code | output | 56 | Active attenuation codes, channel c at bits 8c+7..8c |
| att_mute | output | 7 | Per-channel mute (active code 0x00) |
| cmd_err | output | 1 | One-cycle pulse on a write to an unmapped address |

## Verification
The bench builds the block with its default parameters: 7-bit address, 9-bit data, 54 registers and three stereo pairs. With a 7-bit address, the unmapped space above 0x35 and the two-address gap before the master register are both reachable by random words. Random words are weighted toward the attenuation window, so that update-flag writes often land on a pair whose partner has a pending code different from its active code. Directed cases cover framing abort, the reset address, the reset pin and the mute threshold.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  typedef enum logic [1:0] {
    CMD_PLAIN = 2'd0,
    CMD_ATT   = 2'd1,
    CMD_RESET = 2'd2,
    CMD_BAD   = 2'd3
  } cmd_kind_e;

  // Power-on value of each register, indexed by address.
  function automatic logic [8:0] reg_default(input int unsigned idx);
    logic [8:0] v;
    case (idx)
      0, 4:   v = 9'h121;
      1, 5:   v = 9'h17e;
      2, 6:   v = 9'h07d;
      3:      v = 9'h014;
      7:      v = 9'h194;
      8:      v = 9'h01c;
      9, 10:  v = 9'h002;
      11:     v = 9'h0c2;
      12:     v = 9'h182;
      13:     v = 9'h082;
      14:     v = 9'h00a;
      15:     v = 9'h024;
      16:     v = 9'h009;
      18:     v = 9'h0ff;
      28:     v = 9'h1f0;
      29:     v = 9'h040;
      34:     v = 9'h031;
      35:     v = 9'h00b;
      36:     v = 9'h039;
      38:     v = 9'h010;
      39:     v = 9'h032;
      40:     v = 9'h054;
      41:     v = 9'h076;
      42:     v = 9'h098;
      50:     v = 9'h05e;
      51:     v = 9'h03e;
      default: v = (idx >= 20 && idx <= 27) ? 9'h0ff : 9'h000;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/ccr_shift_in.sv
module ccr_shift_in #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              sdi,
  output logic [WORD_W-1:0] word,
  output logic              word_vld
);
  localparam int CNT_W = $clog2(WORD_W);

  logic             sck_q;
  logic [CNT_W-1:0] cnt;
  logic             rise;

  assign rise = sck & ~sck_q & ~cs_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q    <= 1'b0;
      cnt      <= '0;
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      sck_q    <= sck;
      word_vld <= 1'b0;
      if (cs_n) begin
        cnt <= '0;
      end else if (rise) begin
        word <= {word[WORD_W-2:0], sdi};
        if (cnt == CNT_W'(WORD_W - 1)) begin
          cnt      <= '0;
          word_vld <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R1
  vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld);

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !word_vld);

endmodule

// File: rtl/ccr_decode.sv
module ccr_decode
  import ccr_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int NUM_REGS    = 54,
  parameter int NUM_PAIRS   = 3,
  parameter int ATT_BASE    = 20,
  parameter int MASTER_ADDR = 28,
  parameter int RESET_ADDR  = 53,
  parameter int CH_W        = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output cmd_kind_e         kind,
  output logic [CH_W-1:0]   ch
);
  localparam int ATT_END = ATT_BASE + 2 * NUM_PAIRS;

  always_comb begin
    kind = CMD_PLAIN;
    ch   = '0;
    if (int'(addr) == RESET_ADDR) begin
      kind = CMD_RESET;
    end else if (int'(addr) >= NUM_REGS) begin
      kind = CMD_BAD;
    end else if (int'(addr) >= ATT_END && int'(addr) < MASTER_ADDR) begin
      kind = CMD_BAD;
    end else if (int'(addr) >= ATT_BASE && int'(addr) < ATT_END) begin
      kind = CMD_ATT;
      ch   = CH_W'(int'(addr) - ATT_BASE);
    end else if (int'(addr) == MASTER_ADDR) begin
      kind = CMD_ATT;
      ch   = CH_W'(2 * NUM_PAIRS);
    end
  end

endmodule

// File: rtl/ccr_att_stage.sv
module ccr_att_stage #(
  parameter int                CODE_W   = 8,
  parameter logic [CODE_W-1:0] DEF_CODE = '1
) (
  input  logic              clk,
  input  logic              load_def,
  input  logic              wr,
  input  logic              upd,
  input  logic              sib_upd,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [CODE_W-1:0] shadow_code,
  output logic [CODE_W-1:0] active
);

  always_ff @(posedge clk) begin
    if (load_def)          active <= DEF_CODE;
    else if (wr && upd)    active <= wr_code;
    else if (sib_upd)      active <= shadow_code;
  end

  // R5
  att_hold_chk: assert property (@(posedge clk) disable iff (load_def)
    (!(wr && upd) && !sib_upd) |=> $stable(active));

  // R6
  att_own_chk: assert property (@(posedge clk) disable iff (load_def)
    (wr && upd) |=> active == $past(wr_code));

  // R6
  att_sib_chk: assert property (@(posedge clk) disable iff (load_def)
    (sib_upd && !wr) |=> active == $past(shadow_code));

endmodule

// File: rtl/codec_ctl_regfile.sv
module codec_ctl_regfile
  import ccr_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 9,
  parameter int CODE_W      = 8,
  parameter int NUM_REGS    = 54,
  parameter int NUM_PAIRS   = 3,
  parameter int ATT_BASE    = 20,
  parameter int MASTER_ADDR = 28,
  parameter int RESET_ADDR  = 53
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ctl_sck,
  input  logic                       ctl_cs_n,
  input  logic                       ctl_sdi,
  output logic [NUM_REGS*DATA_W-1:0] reg_flat,
  output logic [(2*NUM_PAIRS+1)*CODE_W-1:0] att_code,
  output logic [2*NUM_PAIRS:0]       att_mute,
  output logic                       cmd_err
);
  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int NCH    = 2 * NUM_PAIRS + 1;
  localparam int CH_W   = $clog2(NCH);
  localparam int IDX_W  = $clog2(NUM_REGS);

  logic [WORD_W-1:0] word;
  logic              word_vld;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  logic [IDX_W-1:0]  addr_idx;
  cmd_kind_e         kind;
  logic [CH_W-1:0]   ch;
  logic              load_def;
  logic              do_store;
  logic              att_wr;
  logic              upd;

  logic [DATA_W-1:0] regs [NUM_REGS];

  ccr_shift_in #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .sck      (ctl_sck),
    .cs_n     (ctl_cs_n),
    .sdi      (ctl_sdi),
    .word     (word),
    .word_vld (word_vld)
  );

  assign addr     = word[WORD_W-1:DATA_W];
  assign data     = word[DATA_W-1:0];
  assign addr_idx = addr[IDX_W-1:0];
  assign upd      = data[DATA_W-1];

  ccr_decode #(
    .ADDR_W      (ADDR_W),
    .NUM_REGS    (NUM_REGS),
    .NUM_PAIRS   (NUM_PAIRS),
    .ATT_BASE    (ATT_BASE),
    .MASTER_ADDR (MASTER_ADDR),
    .RESET_ADDR  (RESET_ADDR),
    .CH_W        (CH_W)
  ) u_dec (
    .addr (addr),
    .kind (kind),
    .ch   (ch)
  );

  assign load_def = rst | (word_vld & (kind == CMD_RESET));
  assign do_store = word_vld & ((kind == CMD_PLAIN) | (kind == CMD_ATT));
  assign att_wr   = word_vld & (kind == CMD_ATT);

  always_ff @(posedge clk) begin
    if (load_def) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= DATA_W'(reg_default(i));
    end else if (do_store) begin
      regs[addr_idx] <= data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cmd_err <= 1'b0;
    else     cmd_err <= word_vld & (kind == CMD_BAD);
  end

  for (genvar a = 0; a < NUM_REGS; a++) begin : g_flat
    assign reg_flat[a*DATA_W +: DATA_W] = regs[a];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int          A   = (c < 2 * NUM_PAIRS) ? ATT_BASE + c : MASTER_ADDR;
    localparam logic [8:0]  DV  = reg_default(A);
    localparam int          SIB = c ^ 1;
    logic sib_upd;
    logic [CODE_W-1:0] act;

    if (c < 2 * NUM_PAIRS) begin : g_pair
      assign sib_upd = att_wr & upd & (ch == CH_W'(SIB));
    end else begin : g_master
      assign sib_upd = 1'b0;
    end

    ccr_att_stage #(
      .CODE_W   (CODE_W),
      .DEF_CODE (CODE_W'(DV))
    ) u_att (
      .clk         (clk),
      .load_def    (load_def),
      .wr          (att_wr & (ch == CH_W'(c))),
      .upd         (upd),
      .sib_upd     (sib_upd),
      .wr_code     (data[CODE_W-1:0]),
      .shadow_code (regs[A][CODE_W-1:0]),
      .active      (act)
    );

    assign att_code[c*CODE_W +: CODE_W] = act;
    assign att_mute[c] = (act == '0);
  end

  // R8
  bad_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (word_vld && kind == CMD_BAD) |=> $stable(reg_flat));

  // R8
  err_src_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> $past(word_vld));

  // R4
  rst_def_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (regs[0] == DATA_W'(reg_default(0)) && !cmd_err));

  // R2
  wr_apply_chk: assert property (@(posedge clk) disable iff (rst)
    do_store |=> regs[$past(addr_idx)] == $past(data));

endmodule

// File: tb/sim_codec_ctl_regfile.sv
module sim_codec_ctl_regfile;
  localparam int NREG = 54;
  localparam int NCH  = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic sdi = 1'b0;
  logic [NREG*9-1:0] reg_flat;
  logic [NCH*8-1:0]  att_code;
  logic [NCH-1:0]    att_mute;
  logic              cmd_err;

  always #2.5 clk = ~clk;

  codec_ctl_regfile u0 (
    .clk(clk), .rst(rst), .ctl_sck(sck), .ctl_cs_n(cs_n), .ctl_sdi(sdi),
    .reg_flat(reg_flat), .att_code(att_code), .att_mute(att_mute), .cmd_err(cmd_err)
  );

  int checks = 0;
  int errors = 0;
  logic [8:0] m_regs [NREG];
  logic [7:0] m_act  [NCH];
  int m_err = 0;
  int err_seen = 0;
  int err_long = 0;
  logic err_prev = 1'b0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (cmd_err) err_seen++;
    if (cmd_err && err_prev) err_long++;
    err_prev <= cmd_err;
  end

  function automatic logic [8:0] exp_def(input int a);
    case (a)
      0: return 9'h121; 1: return 9'h17e; 2: return 9'h07d; 3: return 9'h014;
      4: return 9'h121; 5: return 9'h17e; 6: return 9'h07d; 7: return 9'h194;
      8: return 9'h01c; 9: return 9'h002; 10: return 9'h002; 11: return 9'h0c2;
      12: return 9'h182; 13: return 9'h082; 14: return 9'h00a; 15: return 9'h024;
      16: return 9'h009; 18: return 9'h0ff; 28: return 9'h1f0; 29: return 9'h040;
      34: return 9'h031; 35: return 9'h00b; 36: return 9'h039; 38: return 9'h010;
      39: return 9'h032; 40: return 9'h054; 41: return 9'h076; 42: return 9'h098;
      50: return 9'h05e; 51: return 9'h03e;
      default: return (a >= 20 && a <= 27) ? 9'h0ff : 9'h000;
    endcase
  endfunction

  task automatic model_defaults();
    for (int a = 0; a < NREG; a++) m_regs[a] = exp_def(a);
    for (int c = 0; c < 6; c++) m_act[c] = 8'hff;
    m_act[6] = 8'hf0;
  endtask

  task automatic model_word(input logic [15:0] w);
    int a = int'(w[15:9]);
    logic [8:0] d = w[8:0];
    if (a == 53) model_defaults();
    else if (a >= NREG || a == 26 || a == 27) m_err++;
    else begin
      m_regs[a] = d;
      if (a >= 20 && a <= 25 && d[8]) begin
        m_act[a - 20] = d[7:0];
        m_act[(a - 20) ^ 1] = m_regs[20 + ((a - 20) ^ 1)][7:0];
      end
      if (a == 28 && d[8]) m_act[6] = d[7:0];
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    int bad_a = -1;
    int bad_c = -1;
    int bad_m = -1;
    for (int a = 0; a < NREG; a++)
      if (bad_a < 0 && reg_flat[a*9 +: 9] !== m_regs[a]) bad_a = a;
    for (int c = 0; c < NCH; c++) begin
      if (bad_c < 0 && att_code[c*8 +: 8] !== m_act[c]) bad_c = c;
      if (bad_m < 0 && att_mute[c] !== (m_act[c] == 8'h00)) bad_m = c;
    end
    if (bad_a >= 0) chk(0, req, $sformatf("reg %0h", bad_a), 32'(reg_flat[bad_a*9 +: 9]), 32'(m_regs[bad_a]));
    else chk(1, req, "regs", 0, 0);
    if (bad_c >= 0) chk(0, req, $sformatf("att ch%0d", bad_c), 32'(att_code[bad_c*8 +: 8]), 32'(m_act[bad_c]));
    else chk(1, req, "att", 0, 0);
    if (bad_m >= 0) chk(0, "R10", $sformatf("mute ch%0d", bad_m), 32'(att_mute[bad_m]), 32'(m_act[bad_m] == 8'h00));
    else chk(1, "R10", "mute", 0, 0);
    chk(err_seen == m_err, "R8", "error pulses", 32'(err_seen), 32'(m_err));
  endtask

  task automatic send_bits(input logic [15:0] w, input int n);
    @(negedge clk) cs_n = 1'b0;
    for (int i = 15; i > 15 - n; i--) begin
      sdi = w[i];
      repeat (2) @(negedge clk);
      sck = 1'b1;
      repeat (2) @(negedge clk);
      sck = 1'b0;
    end
    @(negedge clk) cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_word(input logic [15:0] w);
    send_bits(w, 16);
    model_word(w);
  endtask

  function automatic logic [15:0] mk(input int a, input logic [8:0] d);
    return {7'(a), d};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    model_defaults();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check_state("R4");
    chk(reg_flat[8*9 +: 9] === 9'h01c, "R3", "default at 0x08", 32'(reg_flat[8*9 +: 9]), 32'h01c);
    chk(reg_flat[28*9 +: 9] === 9'h1f0, "R3", "default at 0x1C", 32'(reg_flat[28*9 +: 9]), 32'h1f0);

    // R1 R2 plain writes
    send_word(mk(8'h00, 9'h0a5)); check_state("R1");
    send_word(mk(8'h33, 9'h1ff)); check_state("R2");
    // R5 pending code only
    send_word(mk(8'h14, 9'h080)); check_state("R5");
    chk(att_code[7:0] === 8'hff, "R5", "ch0 held", 32'(att_code[7:0]), 32'hff);
    // R6 partner moves with update
    send_word(mk(8'h15, 9'h140)); check_state("R6");
    chk(att_code[7:0] === 8'h80, "R6", "partner ch0", 32'(att_code[7:0]), 32'h80);
    // R7 master with update, code 0 => mute R10
    send_word(mk(8'h1c, 9'h100)); check_state("R7");
    chk(att_mute[6] === 1'b1, "R10", "master mute", 32'(att_mute[6]), 1);
    // R8 gap and high addresses
    send_word(mk(8'h1a, 9'h055)); check_state("R8");
    send_word(mk(8'h7f, 9'h1aa)); check_state("R8");
    // R9 abort then full word
    send_bits(mk(8'h02, 9'h000), 7); check_state("R9");
    send_word(mk(8'h02, 9'h0c3)); check_state("R9");
    // R3 reset register
    send_word(mk(8'h35, 9'h000)); check_state("R3");

    // random words, biased toward attenuation window
    for (int n = 0; n < 120; n++) begin
      int sel = int'($urandom % 10);
      int a;
      if (sel < 4) a = 20 + int'($urandom % 9);
      else if (sel == 4) a = 54 + int'($urandom % 74);
      else if (sel == 5 && ($urandom % 4) == 0) a = 53;
      else a = int'($urandom % 53);
      send_word(mk(a, 9'($urandom)));
      check_state("R6");
    end

    // R4 reset pin after random traffic
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    model_defaults();
    repeat (2) @(negedge clk);
    check_state("R4");
    chk(err_long == 0, "R8", "pulse width", 32'(err_long), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule